// File: doc/BRIEF.md
# Counting Binary-to-Decimal Converter

This block turns a 16-bit unsigned binary number into five binary-coded decimal digits. It does not use any shift-and-correct arithmetic. It copies the operand into a down-counter and then runs a chain of five decade counters. On every active clock the binary copy drops by one and the decade chain rises by one. When the binary copy reaches zero, the decade chain holds the decimal form of the operand.

Each conversion takes as many cycles as the input value, plus one load cycle. The block therefore suits inputs that change slowly, such as a value shown to a person. A caller pulses `start_i` with the operand on `bin_i` while `busy_o` is low. It then waits for the one-cycle `done_o` pulse. The digit outputs keep the result until the next accepted start.

Top module: `cd_bin2bcd_count`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy_o` and `done_o` are 0 and all five digit outputs are 0.
- R2: A `start_i` pulse sampled while `busy_o` is low is accepted. It clears all five digits on that clock edge, and `busy_o` is 1 after that edge when `bin_i` is nonzero.
- R3: Every clock edge during a conversion raises the decimal value held by the digits by exactly one. After k active edges the digits read k.
- R4: Every digit stays within 0 to 9. A digit at 9 that is stepped becomes 0 and steps the next higher digit in the same edge. The order of digits from low to high is ones, tens, hundreds, thousands, ten-thousands.
- R5: When `done_o` is high, `tthou_o`·10000 + `thou_o`·1000 + `hund_o`·100 + `tens_o`·10 + `ones_o` equals the accepted operand.
- R6: For a nonzero operand N, `done_o` is high for exactly one cycle, N edges after the accepting edge. `busy_o` falls on that same edge.
- R7: An operand of 0 raises `done_o` on the cycle after the accepting edge, with all digits 0. `busy_o` never rises.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The result and the cycle on which `done_o` is raised stay unchanged.
- R9: Once a conversion has ended, the digits hold their value until the next accepted start.
- R10: The operand 65535 converts to digits 6,5,5,3,5 and is done 65535 edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register steps on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to convert `bin_i`; acted on only while idle |
| bin_i | input | 16 | Unsigned operand, sampled on the accepting edge |
| busy_o | output | 1 | High while a conversion is counting |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| ones_o | output | 4 | Ones digit |
| tens_o | output | 4 | Tens digit |
| hund_o | output | 4 | Hundreds digit |
| thou_o | output | 4 | Thousands digit |
| tthou_o | output | 4 | Ten-thousands digit |

## Verification
Call the edge that samples the start pulse E0. For a nonzero operand N, `busy_o` is due just after E0. After edge Ek, the digits are due to read k. `done_o` is due just after E_N and must be low again just after E_N+1. For a zero operand, `done_o` is due just after E0. The bench drives inputs on falling edges and counts rising edges from E0. It samples every output on the falling edge after the edge in question, so each check falls on exactly the cycle the requirement names.

// File: rtl/cd_pkg.sv
package cd_pkg;
  localparam int unsigned CD_BIN_W = 16;
  localparam int unsigned CD_NDIG  = 5;
  localparam int unsigned CD_DIG_W = 4;

  // next value of one decade; wraps from 9 to 0
  function automatic logic [CD_DIG_W-1:0] dec_next(input logic [CD_DIG_W-1:0] d);
    if (d == CD_DIG_W'(9)) return '0;
    return d + CD_DIG_W'(1);
  endfunction

  // a decade at its top value passes a step upward
  function automatic logic dec_wraps(input logic [CD_DIG_W-1:0] d);
    return d == CD_DIG_W'(9);
  endfunction

  typedef enum logic [0:0] {CD_IDLE = 1'b0, CD_RUN = 1'b1} cd_state_e;
endpackage

// File: rtl/cd_decade.sv
module cd_decade
  import cd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                inc,
  output logic [CD_DIG_W-1:0] q,
  output logic                carry_o
);
  logic wrap_now;
  assign wrap_now = inc && dec_wraps(q);
  assign carry_o  = wrap_now && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (inc)    q <= dec_next(q);
  end

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    q <= CD_DIG_W'(9)); // R4
  AST_DIGIT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wrap_now && !clr) |=> (q == '0)); // R4
  AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(q)); // R9
endmodule

// File: rtl/cd_decade_chain.sv
module cd_decade_chain
  import cd_pkg::*;
#(
  parameter int unsigned NDIG = CD_NDIG
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr,
  input  logic                           step,
  output logic [NDIG-1:0][CD_DIG_W-1:0]  digits
);
  logic [NDIG:0] ripple;
  assign ripple[0] = step;

  for (genvar g = 0; g < NDIG; g++) begin : g_dec
    cd_decade u_dec (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .inc     (ripple[g]),
      .q       (digits[g]),
      .carry_o (ripple[g+1])
    );
  end

  logic top_carry_unused;
  assign top_carry_unused = ripple[NDIG];
endmodule

// File: rtl/cd_down_counter.sv
module cd_down_counter
  import cd_pkg::*;
#(
  parameter int unsigned W = CD_BIN_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         dec,
  output logic         at_one,
  output logic         at_zero
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)                q <= '0;
    else if (load)          q <= d;
    else if (dec && q != '0) q <= q - W'(1);
  end

  assign at_one  = (q == W'(1));
  assign at_zero = (q == '0);

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && q != '0) |=> (q == W'($past(q) - W'(1)))); // R3
  AST_DOWN_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d))); // R2
endmodule

// File: rtl/cd_ctrl.sv
module cd_ctrl
  import cd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic operand_zero,
  input  logic cnt_one,
  output logic accept,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  cd_state_e state;

  assign busy   = (state == CD_RUN);
  assign accept = start && !busy;
  assign step   = busy;
  assign last   = busy && cnt_one;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CD_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (accept && operand_zero) || last;
      if (accept && !operand_zero) state <= CD_RUN;
      else if (last)               state <= CD_IDLE;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_END_OF_RUN: assert property (@(posedge clk) disable iff (rst)
    last |=> (done && !busy)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last) |=> busy); // R8
  AST_ZERO_DONE: assert property (@(posedge clk) disable iff (rst)
    (accept && operand_zero) |=> (done && !busy)); // R7
endmodule

// File: rtl/cd_bin2bcd_count.sv
module cd_bin2bcd_count
  import cd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [CD_BIN_W-1:0] bin_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [CD_DIG_W-1:0] ones_o,
  output logic [CD_DIG_W-1:0] tens_o,
  output logic [CD_DIG_W-1:0] hund_o,
  output logic [CD_DIG_W-1:0] thou_o,
  output logic [CD_DIG_W-1:0] tthou_o
);
  logic accept, step, last, cnt_one, cnt_zero, operand_zero;
  logic [CD_NDIG-1:0][CD_DIG_W-1:0] digits;

  assign operand_zero = (bin_i == '0);

  cd_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start_i),
    .operand_zero (operand_zero),
    .cnt_one      (cnt_one),
    .accept       (accept),
    .step         (step),
    .last         (last),
    .busy         (busy_o),
    .done         (done_o)
  );

  cd_down_counter #(.W(CD_BIN_W)) u_down (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .d       (bin_i),
    .dec     (step),
    .at_one  (cnt_one),
    .at_zero (cnt_zero)
  );

  cd_decade_chain #(.NDIG(CD_NDIG)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .step   (step),
    .digits (digits)
  );

  assign ones_o  = digits[0];
  assign tens_o  = digits[1];
  assign hund_o  = digits[2];
  assign thou_o  = digits[3];
  assign tthou_o = digits[4];

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
    accept |=> (digits == '0 || busy_o)); // R2
  AST_BUSY_NONZERO: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !cnt_zero); // R6
endmodule

// File: tb/tb_cd_bin2bcd_count.sv
module tb_cd_bin2bcd_count;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] bin_i = '0;
  logic        busy_o, done_o;
  logic [3:0]  ones_o, tens_o, hund_o, thou_o, tthou_o;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cd_bin2bcd_count dut (
    .clk(clk), .rst(rst), .start_i(start_i), .bin_i(bin_i),
    .busy_o(busy_o), .done_o(done_o), .ones_o(ones_o), .tens_o(tens_o),
    .hund_o(hund_o), .thou_o(thou_o), .tthou_o(tthou_o)
  );

  function automatic int shown();
    return tthou_o*10000 + thou_o*1000 + hund_o*100 + tens_o*10 + ones_o;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic digits_legal(input string req);
    chk(req, int'(ones_o <= 9 && tens_o <= 9 && hund_o <= 9 && thou_o <= 9 && tthou_o <= 9), 1);
  endtask

  // start at falling edge; returns just after E0's falling edge
  task automatic kick(input int n);
    bin_i = 16'(n); start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 done in reset", done_o, 0);
    chk("R1 digits in reset", shown(), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", busy_o, 0);
    chk("R1 digits after reset", shown(), 0);
  endtask

  // R2 R3 R4 R5 R6: full conversion with per-edge tracking
  task automatic t_convert(input int n, input bit trace);
    kick(n);
    chk("R2 busy after accept", busy_o, 1);
    chk("R2 digits cleared", shown(), 0);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (trace || k == n) begin
        chk("R3 running value", shown(), k);
        digits_legal("R4 digit range");
      end
      if (k < n) begin
        if (trace) chk("R6 no early done", done_o, 0);
        if (busy_o !== 1'b1) chk("R6 busy held", busy_o, 1);
      end
    end
    chk("R6 done at N edges", done_o, 1);
    chk("R6 busy falls with done", busy_o, 0);
    chk("R5 result", shown(), n);
    @(negedge clk);
    chk("R6 done is one cycle", done_o, 0);
  endtask

  task automatic t_zero();
    kick(0);
    chk("R7 done next cycle", done_o, 1);
    chk("R7 busy stays low", busy_o, 0);
    chk("R7 digits zero", shown(), 0);
    @(negedge clk);
    chk("R7 done one cycle", done_o, 0);
  endtask

  task automatic t_busy_ignore();
    kick(50);
    repeat (10) @(negedge clk);
    bin_i = 16'd7; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 value unaffected", shown(), 11);
    repeat (38) @(negedge clk);
    chk("R8 done not early", done_o, 0);
    @(negedge clk);
    chk("R8 done on time", done_o, 1);
    chk("R8 result unchanged", shown(), 50);
  endtask

  task automatic t_hold();
    t_convert(321, 1'b0);
    bin_i = 16'd9999;
    repeat (20) @(negedge clk);
    chk("R9 digits held", shown(), 321);
    chk("R9 still idle", busy_o, 0);
  endtask

  task automatic t_max();
    t_convert(65535, 1'b0);
    chk("R10 ten-thousands", tthou_o, 6);
    chk("R10 thousands", thou_o, 5);
    chk("R10 hundreds", hund_o, 5);
    chk("R10 tens", tens_o, 3);
    chk("R10 ones", ones_o, 5);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_zero();
    t_convert(1, 1'b1);
    t_convert(9, 1'b1);
    t_convert(10, 1'b1);
    t_convert(100, 1'b1);
    t_convert(1234, 1'b1);
    t_convert(10000, 1'b0);
    t_busy_ignore();
    t_hold();
    t_max();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule